// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Core

The core generates a 64-bit keystream from three linear feedback shift registers of 19, 22 and 23 bits that step irregularly. Each cycle a majority vote over one control bit per register decides which registers advance. At least two of the three advance every cycle. The output bit is the XOR of the three register MSBs.

A run starts when the load strobe captures a raw 64-bit state straight into the registers. The core has no key or frame mixing and no warm-up discard. The first output bit comes from the loaded state. The core then makes 63 clock steps and so emits 64 bits, one per cycle, each qualified by a valid flag. A done pulse follows the run. The `LANES` parameter replicates the core: bit position `l` of every control and status port belongs to lane `l`, and the lanes run with no dependence on one another.

Top module: `maj_lfsr_keystream`

## Requirements
- R1: The first register takes load bits [18:0]. Its feedback is the XOR of its bits 18, 17, 16 and 13, and its control bit is bit 8.
- R2: The second register takes load bits [40:19] (register bit k = load bit 19+k). Its feedback is the XOR of its bits 21 and 20, and its control bit is bit 10.
- R3: The third register takes load bits [63:41] (register bit k = load bit 41+k). Its feedback is the XOR of its bits 22, 21, 20 and 7, and its control bit is bit 10.
- R4: A register steps only when its control bit equals the majority of the three control bits, so at least two registers step on every step cycle.
- R5: A stepping register shifts one place toward its MSB and takes the feedback into bit 0. A register that does not step keeps all of its bits.
- R6: `bit_o` is the XOR of the three MSBs before that cycle's stepping. The first bit, in the cycle after the load edge, comes from the loaded state itself.
- R7: `valid_o` is high for exactly 64 consecutive cycles after a load edge, and 63 steps happen in that time. `done_o` is high for one cycle immediately after the 64th bit, and `valid_o` is low in that cycle.
- R8: Each lane loads, steps, votes and signals on its own bit of the per-lane masks. Activity in one lane does not change another lane's outputs, and an idle lane shows `valid_o` and `done_o` low.
- R9: A load during a run, including in the cycle of the 64th bit, restarts the lane from the new state, and no done pulse is produced for the aborted run.
- R10: After reset all lanes are idle, with `bit_o`, `valid_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | LANES | Per-lane load strobe |
| state_i | input | 64*LANES | Per-lane raw state; lane l uses bits [64l+63:64l] |
| bit_o | output | LANES | Per-lane keystream bit |
| valid_o | output | LANES | Per-lane keystream bit qualifier |
| done_o | output | LANES | Per-lane end-of-run pulse |

## Verification
The all-zero state tells whether the registers stay frozen with no feedback. The all-ones state tells whether the vote steps all three registers when their control bits agree. A single set bit is walked across all 64 state positions. Each such run tells whether that bit lands in the right register and cell, and whether the taps and control bits are the right ones, because an error in any of these shows up as a different bit stream. Pseudo-random states, each lane loaded at a different time, and reloads in the middle of a run and in the cycle of the final bit tell whether the lanes are independent and whether the restart and done rules hold.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int STATE_W = 64;
  localparam int RUN_LEN = 64;
  localparam int CNT_W   = $clog2(RUN_LEN);

  localparam int A_W = 19;
  localparam int B_W = 22;
  localparam int C_W = 23;

  localparam int A_LO = 0;
  localparam int B_LO = A_LO + A_W;
  localparam int C_LO = B_LO + B_W;

  localparam logic [A_W-1:0] A_TAPS = A_W'((1 << 18) | (1 << 17) | (1 << 16) | (1 << 13));
  localparam logic [B_W-1:0] B_TAPS = B_W'((1 << 21) | (1 << 20));
  localparam logic [C_W-1:0] C_TAPS = C_W'((1 << 22) | (1 << 21) | (1 << 20) | (1 << 7));

  localparam int A_CBIT = 8;
  localparam int B_CBIT = 10;
  localparam int C_CBIT = 10;
endpackage

// File: rtl/lfsr_stage.sv
module lfsr_stage #(
  parameter int             W    = 19,
  parameter logic [W-1:0]   TAPS = '0,
  parameter int             CBIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic         msb_o,
  output logic         ctl_o
);
  logic [W-1:0] r_q;
  logic         fb;

  assign fb    = ^(r_q & TAPS);
  assign msb_o = r_q[W-1];
  assign ctl_o = r_q[CBIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_q <= '0;
    else if (load_i) r_q <= load_val_i;
    else if (step_i) r_q <= {r_q[W-2:0], fb};
  end

  // R5
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (r_q[W-1:1] == $past(r_q[W-2:0])));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(r_q));
  // R1
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (r_q == $past(load_val_i)));
endmodule

// File: rtl/maj_vote.sv
module maj_vote (
  input  logic       en_i,
  input  logic [2:0] ctl_i,
  output logic [2:0] step_o
);
  logic maj;
  assign maj = (ctl_i[0] & ctl_i[1]) | (ctl_i[0] & ctl_i[2]) | (ctl_i[1] & ctl_i[2]);

  always_comb begin
    for (int k = 0; k < 3; k++) step_o[k] = en_i & (ctl_i[k] == maj);
  end
endmodule

// File: rtl/ks_lane.sv
module ks_lane
  import ks_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               bit_o,
  output logic               valid_o,
  output logic               done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step_en;
  logic [2:0]       ctl, step, msb;

  assign step_en = active_q & ~load_i & (cnt_q != LAST);

  lfsr_stage #(.W(A_W), .TAPS(A_TAPS), .CBIT(A_CBIT)) u_ra (
    .clk_i, .rst_ni, .load_i,
    .load_val_i(state_i[A_LO +: A_W]),
    .step_i(step[0]), .msb_o(msb[0]), .ctl_o(ctl[0]));

  lfsr_stage #(.W(B_W), .TAPS(B_TAPS), .CBIT(B_CBIT)) u_rb (
    .clk_i, .rst_ni, .load_i,
    .load_val_i(state_i[B_LO +: B_W]),
    .step_i(step[1]), .msb_o(msb[1]), .ctl_o(ctl[1]));

  lfsr_stage #(.W(C_W), .TAPS(C_TAPS), .CBIT(C_CBIT)) u_rc (
    .clk_i, .rst_ni, .load_i,
    .load_val_i(state_i[C_LO +: C_W]),
    .step_i(step[2]), .msb_o(msb[2]), .ctl_o(ctl[2]));

  maj_vote u_vote (.en_i(step_en), .ctl_i(ctl), .step_o(step));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= active_q & ~load_i & (cnt_q == LAST);
      if (load_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (cnt_q == LAST) active_q <= 1'b0;
        else               cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign valid_o = active_q;
  assign done_o  = done_q;
  assign bit_o   = active_q & (^msb);

  // R4
  two_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |-> ($countones(step) >= 2));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_novalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  // R9
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (valid_o && !done_o));
  // R7
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_o));
endmodule

// File: rtl/maj_lfsr_keystream.sv
module maj_lfsr_keystream
  import ks_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES-1:0]         load_i,
  input  logic [LANES*STATE_W-1:0] state_i,
  output logic [LANES-1:0]         bit_o,
  output logic [LANES-1:0]         valid_o,
  output logic [LANES-1:0]         done_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ks_lane u_lane (
      .clk_i,
      .rst_ni,
      .load_i (load_i[l]),
      .state_i(state_i[l*STATE_W +: STATE_W]),
      .bit_o  (bit_o[l]),
      .valid_o(valid_o[l]),
      .done_o (done_o[l])
    );
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (valid_o == '0 && done_o == '0));
endmodule

// File: tb/maj_lfsr_keystream_tb.sv
module maj_lfsr_keystream_tb;
  localparam int LANES = 4;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [LANES-1:0]      load_i = '0;
  logic [LANES*64-1:0]   state_bus = '0;
  logic [LANES-1:0]      bit_o, valid_o, done_o;

  int checks = 0;
  int errors = 0;
  int pos [LANES];
  logic [63:0] exp_s [LANES];
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk_i = ~clk_i;

  maj_lfsr_keystream #(.LANES(LANES)) u_dut (
    .clk_i, .rst_ni, .load_i, .state_i(state_bus), .bit_o, .valid_o, .done_o);

  function automatic logic [63:0] ref_stream(input logic [63:0] s);
    logic [18:0] a = s[18:0];
    logic [21:0] b = s[40:19];
    logic [22:0] c = s[63:41];
    logic [63:0] o = '0;
    logic ca, cb, cc, m;
    for (int i = 0; i < 64; i++) begin
      o[i] = a[18] ^ b[21] ^ c[22];
      ca = a[8]; cb = b[10]; cc = c[10];
      m  = (ca & cb) | (ca & cc) | (cb & cc);
      if (ca == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
      if (cb == m) b = {b[20:0], b[21] ^ b[20]};
      if (cc == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
    end
    return o;
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic chk(input bit ok, input string tg, input int l, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane %0d %s: got %0h expected %0h", tg, l, what, got, exp);
    end
  endtask

  task automatic tick(input logic [LANES-1:0] m, input string tg);
    @(negedge clk_i);
    for (int l = 0; l < LANES; l++) begin
      if (pos[l] >= 0 && pos[l] < 64) begin
        chk(valid_o[l] === 1'b1, "R7", l, "valid", 8'(valid_o[l]), 8'd1);
        chk(done_o[l] === 1'b0, "R9", l, "done in run", 8'(done_o[l]), 8'd0);
        chk(bit_o[l] === exp_s[l][pos[l]], tg, l, $sformatf("bit %0d", pos[l]),
            8'(bit_o[l]), 8'(exp_s[l][pos[l]]));
        pos[l]++;
      end else if (pos[l] == 64) begin
        chk(done_o[l] === 1'b1 && valid_o[l] === 1'b0, "R7", l, "done/valid",
            {6'd0, done_o[l], valid_o[l]}, 8'b10);
        pos[l] = -1;
      end else begin
        chk(valid_o[l] === 1'b0 && done_o[l] === 1'b0, "R8", l, "idle done/valid",
            {6'd0, done_o[l], valid_o[l]}, 8'b00);
      end
    end
    load_i = m;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        exp_s[l] = ref_stream(state_bus[l*64 +: 64]);
        pos[l]   = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick('0, "R8");
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) pos[l] = -1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: reset state
    for (int l = 0; l < LANES; l++)
      chk(bit_o[l] === 1'b0 && valid_o[l] === 1'b0 && done_o[l] === 1'b0, "R10", l,
          "reset outputs", {5'd0, bit_o[l], done_o[l], valid_o[l]}, 8'd0);
    rst_ni = 1'b1;
    idle(2);

    // R6: corner states, zero / ones / mixed
    state_bus[0*64 +: 64] = '0;
    state_bus[1*64 +: 64] = '1;
    state_bus[2*64 +: 64] = 64'hAAAA_AAAA_AAAA_AAAA;
    state_bus[3*64 +: 64] = 64'h0123_4567_89AB_CDEF;
    tick('1, "R6");
    idle(70);

    // R1 R2 R3: walk a single set bit across every state position
    for (int b = 0; b < 64; b++) begin
      for (int l = 0; l < LANES; l++) begin
        seed = next_rand(seed);
        state_bus[l*64 +: 64] = (l == 0) ? (64'd1 << b) : ((64'd1 << b) ^ seed);
      end
      tick('1, (b < 19) ? "R1" : (b < 41) ? "R2" : "R3");
      idle(65);
    end

    // R4 R5: pseudo-random sweep, back-to-back runs
    for (int r = 0; r < 40; r++) begin
      for (int l = 0; l < LANES; l++) begin
        seed = next_rand(seed);
        state_bus[l*64 +: 64] = seed;
      end
      tick('1, (r % 2 == 0) ? "R4" : "R5");
      for (int i = 0; i < 64; i++) tick('0, (r % 2 == 0) ? "R4" : "R5");
    end
    idle(3);

    // R8: staggered lane starts
    for (int l = 0; l < LANES; l++) begin
      seed = next_rand(seed);
      state_bus[l*64 +: 64] = seed;
      tick(LANES'(1) << l, "R8");
      for (int i = 0; i < 4; i++) tick('0, "R8");
    end
    idle(70);

    // R9: abort mid-run and reload in the last-bit cycle
    for (int l = 0; l < LANES; l++) begin
      seed = next_rand(seed);
      state_bus[l*64 +: 64] = seed;
    end
    tick('1, "R9");
    for (int i = 0; i < 20; i++) tick('0, "R9");
    seed = next_rand(seed);
    state_bus[0 +: 64] = seed;
    tick(4'b0001, "R9");
    while (pos[1] != 63) tick('0, "R9");
    seed = next_rand(seed);
    state_bus[64 +: 64] = seed;
    tick(4'b0010, "R9");
    idle(70);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule